// File: doc/BRIEF.md
# Beat-Period Random Bit Digitizer

This block is the digital back end of a random bit generator that uses two free-running ring oscillators of almost equal frequency. The first oscillator is the block's clock. A flip-flop clocked by it samples the second oscillator, and the result is a slow beat waveform. The beat is synchronized and its period is measured in clock cycles. Timing jitter makes the exact length of each period random, so the low bit of each measured length is emitted as one random bit. The mean length is roughly the clock period divided by the period difference of the two oscillators, so closer matching gives longer counts.

A closed-loop controller selects the configuration code of each oscillator. It walks through a list of code pairs and averages a set of measured periods for each pair. It keeps the first pair whose mean falls inside a window set at two input ports. While running, it watches every period for health. Repeated short or missing beats send it back to calibration. If no pair in the list gives usable matching, it raises a sticky failure flag.

Top module: `beat_rng_digitizer`

## Requirements
- R1: The beat is `osc_in` sampled on the rising edge of `clk_smp` and then passed through a two-flop synchronizer. A period is the number of `clk_smp` cycles from one rising edge of the synchronized beat to the next.
- R2: In the running state, each completed period whose length is at least `lo_bound` produces a one-cycle `rnd_vld` pulse. `rnd_bit` equals bit 0 of that length. Shorter periods produce no pulse.
- R3: Code pair k drives `cfg_a` = k and `cfg_b` = NPAIR-1-k. Pairs are tried from k = 0 upward. After each change of pair, the first completed period is discarded. The pair is accepted when the mean of the next 16 samples lies in [`lo_bound`, `hi_bound`] inclusive. Acceptance raises `cal_done`, and the codes then stay fixed.
- R4: If 2^CNT_W-1 cycles pass without a beat edge, the counter saturates. During calibration this counts as a sample of value 2^CNT_W-1. While running it counts as an error.
- R5: If the last pair is rejected, `cal_fail` goes high and stays high until reset, whatever `en` does. `cal_done` and `rnd_vld` then stay low, and the codes keep the last pair.
- R6: While running, four consecutive errors restart calibration from pair 0. An error is a period below `lo_bound` or a saturation. Any accepted period clears the error run.
- R7: When `en` is low and the block has not failed, `cal_done` is low one cycle later. A later rise of `en` restarts calibration from pair 0.
- R8: After reset, `cal_done`, `cal_fail` and `rnd_vld` are low. `rnd_vld` is never high while `cal_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sampling oscillator, used as the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Sampled oscillator |
| en | input | 1 | Enables calibration and bit generation |
| lo_bound | input | CNT_W | Lower bound of an acceptable period and of the calibration mean |
| hi_bound | input | CNT_W | Upper bound of the calibration mean |
| cfg_a | output | CFG_W | Configuration code for the sampling oscillator |
| cfg_b | output | CFG_W | Configuration code for the sampled oscillator |
| rnd_bit | output | 1 | Random bit, valid with rnd_vld |
| rnd_vld | output | 1 | One-cycle strobe per emitted bit |
| cal_done | output | 1 | High while matching is found and bits are produced |
| cal_fail | output | 1 | Sticky flag: no code pair gave usable matching |

## Verification
A beat edge reaches the counter after the sampling flop and two synchronizer flops. The measured length is registered one cycle later, and the strobe one cycle after that. The delay from edge to strobe is therefore the same for every period, and the bench recovers each length as the spacing between consecutive `rnd_vld` pulses. It checks `rnd_bit` against bit 0 of that spacing. Enable and failure results are due one cycle after the stimulus, so the bench samples them on the next falling edge. Calibration results take many beat periods, so the bench waits for `cal_done` or `cal_fail` under a bounded cycle limit and then checks the selected codes.

// File: rtl/beat_rng_pkg.sv
package beat_rng_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CAL  = 2'd1,
      ST_RUN  = 2'd2,
      ST_FAIL = 2'd3
   } ctl_state_t;
endpackage

// File: rtl/beat_sampler.sv
module beat_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_i,
   output logic rise_o
);
   logic                   smp_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   // the sampling flop: produces the raw beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= 1'b0;
      else        smp_q <= osc_i;
   end

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= smp_q;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/beat_period_counter.sv
module beat_period_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             rise_i,
   output logic             done_o,
   output logic             sat_o,
   output logic [CNT_W-1:0] len_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         done_o  <= 1'b0;
         sat_o   <= 1'b0;
         len_o   <= '0;
      end else begin
         done_o <= 1'b0;
         sat_o  <= 1'b0;
         if (restart_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (rise_i) begin
            if (armed_q) begin
               done_o <= 1'b1;
               len_o  <= cnt_q;
            end
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
         end else if (cnt_q == CNT_MAX) begin
            // no edge for a full count: report and start over
            sat_o   <= 1'b1;
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/beat_cal_ctrl.sv
module beat_cal_ctrl
   import beat_rng_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int NPAIR    = 8,
   parameter int AVG_LOG2 = 4,
   parameter int ERR_LIM  = 4,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             done_i,
   input  logic             sat_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             restart_o,
   output logic             vld_o,
   output logic             bit_o,
   output logic             run_o,
   output logic             fail_o
);
   localparam int               ACC_W   = CNT_W + AVG_LOG2;
   localparam int               ERR_W   = $clog2(ERR_LIM + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   ctl_state_t          state_q;
   logic                skip_q;
   logic [AVG_LOG2-1:0] nsamp_q;
   logic [ACC_W-1:0]    acc_q;
   logic [ERR_W-1:0]    errs_q;

   logic             ev, bad, mean_ok;
   logic [CNT_W-1:0] smp, mean;
   logic [ACC_W-1:0] acc_nxt;

   always_comb begin
      ev      = done_i | sat_i;
      smp     = sat_i ? CNT_MAX : len_i;
      acc_nxt = acc_q + ACC_W'(smp);
      mean    = CNT_W'(acc_nxt >> AVG_LOG2);
      mean_ok = (mean >= lo_i) && (mean <= hi_i);
      bad     = sat_i | (done_i && (len_i < lo_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_o     <= '0;
         restart_o <= 1'b0;
         skip_q    <= 1'b0;
         nsamp_q   <= '0;
         acc_q     <= '0;
         errs_q    <= '0;
         vld_o     <= 1'b0;
         bit_o     <= 1'b0;
      end else begin
         vld_o     <= 1'b0;
         restart_o <= 1'b0;
         if (state_q == ST_FAIL) begin
            state_q <= ST_FAIL;
         end else if (!en_i) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  state_q   <= ST_CAL;
                  idx_o     <= '0;
                  restart_o <= 1'b1;
                  skip_q    <= 1'b1;
                  acc_q     <= '0;
                  nsamp_q   <= '0;
               end
               ST_CAL: if (ev) begin
                  if (skip_q) begin
                     skip_q <= 1'b0;
                  end else if (nsamp_q == {AVG_LOG2{1'b1}}) begin
                     if (mean_ok) begin
                        state_q <= ST_RUN;
                        errs_q  <= '0;
                     end else if (idx_o == IDX_W'(NPAIR - 1)) begin
                        state_q <= ST_FAIL;
                     end else begin
                        idx_o     <= idx_o + 1'b1;
                        restart_o <= 1'b1;
                        skip_q    <= 1'b1;
                        acc_q     <= '0;
                        nsamp_q   <= '0;
                     end
                  end else begin
                     acc_q   <= acc_nxt;
                     nsamp_q <= nsamp_q + 1'b1;
                  end
               end
               ST_RUN: begin
                  if (bad) begin
                     if (errs_q == ERR_W'(ERR_LIM - 1)) begin
                        state_q   <= ST_CAL;
                        idx_o     <= '0;
                        restart_o <= 1'b1;
                        skip_q    <= 1'b1;
                        acc_q     <= '0;
                        nsamp_q   <= '0;
                     end else begin
                        errs_q <= errs_q + 1'b1;
                     end
                  end else if (done_i) begin
                     errs_q <= '0;
                     vld_o  <= 1'b1;
                     bit_o  <= len_i[0];
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign run_o  = (state_q == ST_RUN);
   assign fail_o = (state_q == ST_FAIL);
endmodule

// File: rtl/beat_rng_digitizer.sv
module beat_rng_digitizer #(
   parameter int CNT_W       = 16,
   parameter int CFG_W       = 4,
   parameter int NPAIR       = 8,
   parameter int AVG_LOG2    = 4,
   parameter int ERR_LIM     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PAIR_ORDER  = 0
) (
   input  logic             clk_smp,
   input  logic             rst_n,
   input  logic             osc_in,
   input  logic             en,
   input  logic [CNT_W-1:0] lo_bound,
   input  logic [CNT_W-1:0] hi_bound,
   output logic [CFG_W-1:0] cfg_a,
   output logic [CFG_W-1:0] cfg_b,
   output logic             rnd_bit,
   output logic             rnd_vld,
   output logic             cal_done,
   output logic             cal_fail
);
   localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;

   generate
      if (CFG_W < IDX_W) begin : g_bad_cfg
         $error("CFG_W too narrow for NPAIR");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (AVG_LOG2 < 1) begin : g_bad_avg
         $error("AVG_LOG2 must be at least 1");
      end
      if (ERR_LIM < 2) begin : g_bad_err
         $error("ERR_LIM must be at least 2");
      end
   endgenerate

   logic             beat_rise, per_done, per_sat, restart;
   logic [CNT_W-1:0] per_len;
   logic [IDX_W-1:0] pair_idx;

   beat_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk   (clk_smp),
      .rst_n (rst_n),
      .osc_i (osc_in),
      .rise_o(beat_rise)
   );

   beat_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk_smp),
      .rst_n    (rst_n),
      .restart_i(restart),
      .rise_i   (beat_rise),
      .done_o   (per_done),
      .sat_o    (per_sat),
      .len_o    (per_len)
   );

   beat_cal_ctrl #(
      .CNT_W(CNT_W), .NPAIR(NPAIR), .AVG_LOG2(AVG_LOG2),
      .ERR_LIM(ERR_LIM), .IDX_W(IDX_W)
   ) u_ctl (
      .clk      (clk_smp),
      .rst_n    (rst_n),
      .en_i     (en),
      .done_i   (per_done),
      .sat_i    (per_sat),
      .len_i    (per_len),
      .lo_i     (lo_bound),
      .hi_i     (hi_bound),
      .idx_o    (pair_idx),
      .restart_o(restart),
      .vld_o    (rnd_vld),
      .bit_o    (rnd_bit),
      .run_o    (cal_done),
      .fail_o   (cal_fail)
   );

   assign cfg_a = CFG_W'(pair_idx);

   generate
      if (PAIR_ORDER == 0) begin : g_mirror
         assign cfg_b = CFG_W'(NPAIR - 1) - CFG_W'(pair_idx);
      end else begin : g_same
         assign cfg_b = CFG_W'(pair_idx);
      end
   endgenerate
endmodule

// File: rtl/beat_rng_chk.sv
module beat_rng_chk #(
   parameter int CNT_W = 16,
   parameter int CFG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             rnd_vld,
   input logic             rnd_bit,
   input logic             cal_done,
   input logic             cal_fail,
   input logic [CNT_W-1:0] len,
   input logic [CNT_W-1:0] lo,
   input logic [CFG_W-1:0] cfg_a
);
   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld |=> !rnd_vld); // R2
   AST_BIT_IS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld |-> (rnd_bit == $past(len[0]))); // R2
   AST_VLD_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld |-> ($past(len) >= $past(lo))); // R2
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> (!cal_done || $stable(cfg_a))); // R3
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cal_fail |=> cal_fail); // R5
   AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cal_fail |-> (!cal_done && !rnd_vld)); // R5
   AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cal_fail) |=> !cal_done); // R7
   AST_VLD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld |-> cal_done); // R8
endmodule

bind beat_rng_digitizer beat_rng_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
   .clk     (clk_smp),
   .rst_n   (rst_n),
   .en      (en),
   .rnd_vld (rnd_vld),
   .rnd_bit (rnd_bit),
   .cal_done(cal_done),
   .cal_fail(cal_fail),
   .len     (per_len),
   .lo      (lo_bound),
   .cfg_a   (cfg_a)
);

// File: tb/sim_beat_rng_digitizer.sv
`timescale 1ps/1ps
module sim_beat_rng_digitizer;
   localparam int CNT_W = 10;
   localparam int CFG_W = 4;
   localparam int NPAIR = 4;
   localparam int LO    = 20;
   localparam int HI    = 200;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             osc = 1'b0;
   logic             en = 1'b0;
   logic [CNT_W-1:0] lo_bound = CNT_W'(LO);
   logic [CNT_W-1:0] hi_bound = CNT_W'(HI);
   logic [CFG_W-1:0] cfg_a, cfg_b;
   logic             rnd_bit, rnd_vld, cal_done, cal_fail;

   int n_chk = 0;
   int n_err = 0;
   int mode = 0;
   int stray_vld = 0;
   int cyc = 0;

   beat_rng_digitizer #(.CNT_W(CNT_W), .CFG_W(CFG_W), .NPAIR(NPAIR)) u0 (
      .clk_smp(clk), .rst_n(rst_n), .osc_in(osc), .en(en),
      .lo_bound(lo_bound), .hi_bound(hi_bound),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .rnd_bit(rnd_bit), .rnd_vld(rnd_vld),
      .cal_done(cal_done), .cal_fail(cal_fail)
   );

   always #2000 clk = ~clk;

   // period excess of the sampled oscillator, in ps, per mode and pair
   function automatic int excess(int m, int k);
      case (m)
         0: return (k == 0) ? 10 : ((k == 1) ? 40 : 500);  // pair0 too long
         1: return (k == 2) ? 40 : 500;                    // pairs 0,1 too short
         2: return (k == 0) ? 0 : ((k == 1) ? 40 : 500);   // pair0 never beats
         default: return 500;                              // nothing usable
      endcase
   endfunction

   initial begin
      #1;
      forever begin
         #((4000 + excess(mode, int'(cfg_a))) / 2);
         osc = ~osc;
      end
   end

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rnd_vld && !cal_done) stray_vld <= stray_vld + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_flag(input bit want_fail, input int limit, output bit got);
      got = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (want_fail ? cal_fail : cal_done) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      do_reset();
      chk(!cal_done && !cal_fail && !rnd_vld, "R8 reset state",
          {cal_done, cal_fail, rnd_vld}, 0);
   endtask

   task automatic t_cal_upper;
      bit got;
      mode = 0;
      en = 1'b1;
      wait_flag(1'b0, 40000, got);
      chk(got, "R3 calibration completes", got, 1);
      chk(cfg_a == 1, "R3 long pair0 rejected, pair1 kept", cfg_a, 1);
      chk(cfg_b == NPAIR - 2, "R3 mirrored code", cfg_b, NPAIR - 2);
   endtask

   task automatic t_bits;
      int last = -1, n = 0, intv;
      for (int i = 0; i < 5000 && n < 20; i++) begin
         @(negedge clk);
         if (rnd_vld) begin
            if (last >= 0) begin
               intv = cyc - last;
               chk(rnd_bit == intv[0], "R2 bit is period lsb", rnd_bit, intv & 1);
               chk(intv >= LO && intv <= HI, "R1 period length", intv, 100);
               n++;
            end
            last = cyc;
         end
      end
      chk(n == 20, "R2 strobes produced", n, 20);
   endtask

   task automatic t_enable;
      bit got;
      en = 1'b0;
      @(negedge clk);
      chk(!cal_done, "R7 disable drops done", cal_done, 0);
      repeat (500) @(negedge clk);
      chk(!cal_done && !rnd_vld, "R7 stays idle", cal_done, 0);
      en = 1'b1;
      repeat (3) @(negedge clk);
      chk(cfg_a == 0 && !cal_done, "R7 restart from pair0", cfg_a, 0);
      wait_flag(1'b0, 40000, got);
      chk(got && cfg_a == 1, "R7 recalibrated", cfg_a, 1);
   endtask

   task automatic t_health;
      bit got;
      mode = 1;
      got = 1'b0;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (!cal_done) begin got = 1'b1; break; end
      end
      chk(got, "R6 short periods leave run", got, 1);
      wait_flag(1'b0, 40000, got);
      chk(got && cfg_a == 2, "R6 recalibrated to pair2", cfg_a, 2);
   endtask

   task automatic t_sat;
      bit got;
      do_reset();
      mode = 2;
      en = 1'b1;
      repeat (5000) @(negedge clk);
      chk(!cal_done && cfg_a == 0, "R4 no beat, still on pair0", cfg_a, 0);
      wait_flag(1'b0, 60000, got);
      chk(got && cfg_a == 1, "R4 saturated pair rejected", cfg_a, 1);
   endtask

   task automatic t_fail;
      bit got;
      do_reset();
      mode = 3;
      en = 1'b1;
      wait_flag(1'b1, 40000, got);
      chk(got, "R5 failure raised", got, 1);
      chk(cfg_a == NPAIR - 1 && !cal_done, "R5 last pair held", cfg_a, NPAIR - 1);
      en = 1'b0;
      repeat (5) @(negedge clk);
      chk(cal_fail, "R5 sticky with enable low", cal_fail, 1);
      en = 1'b1;
      repeat (300) @(negedge clk);
      chk(cal_fail && !cal_done, "R5 sticky after re-enable", cal_fail, 1);
      do_reset();
      chk(!cal_fail, "R5 cleared by reset", cal_fail, 0);
   endtask

   initial begin
      t_reset();
      t_cal_upper();
      t_bits();
      t_enable();
      t_health();
      t_sat();
      t_fail();
      chk(stray_vld == 0, "R8 strobe outside run", stray_vld, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(190000 * 4000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule